// File: doc/BRIEF.md
# Register Block Stack Sequencer

This block moves the whole set of eight 16-bit general registers between a register file and a word-wide stack in memory, one word per memory transaction. A one-cycle start pulse launches a save (all eight words are written below the current stack pointer) or a restore (eight words are read upward from the stack pointer and loaded back). The sequencer reads the register file through a single read port, which it steers with a register index. It drives a request/ready memory handshake and, once the sequence is complete, reports the new stack pointer together with a one-cycle completion pulse.

Registers are numbered with the usual encoding AX=0, CX=1, DX=2, BX=3, SP=4, BP=5, SI=6, DI=7. On a save, the word stored in the stack-pointer slot is the stack pointer value captured at start. On a restore, that slot is fetched from memory and dropped. Restored values are held in a shadow buffer and committed to the register file in a single cycle, only after the last read has returned. A fault input cancels a sequence that is in flight. In that case the stack pointer and the registers keep their values, and an abort pulse is raised in place of the completion pulse. Segment bases, protection and fault classification belong to the surrounding pipeline.

Top module: `regblk_stack_seq`

## Requirements
- R1: A save issues eight writes in the order of register index 0 to 7. Write k (k = 0..7) stores register k at address SP-2(k+1). The bench register file returns register `rf_rd_idx` on `rf_rd_data` in the same cycle.
- R2: The word stored by a save at SP-10 (index 4) is the low 16 bits of `sp_in` as sampled on the start cycle. It is not the register-file content.
- R3: A completed save pulses `done` and `sp_we` together, with `sp_out` equal to the start stack pointer minus 16. `rf_we` stays all zero.
- R4: A restore issues eight reads at SP+0, SP+2, ... SP+14, in ascending order. The word at SP+2k is destined for register 7-k. The word at SP+6 is never written to any register, so `rf_we` bit 4 is never set.
- R5: A completed restore asserts `done`, `sp_we` and `rf_we` = 8'b1110_1111 in the same single cycle. Register i is taken from `rf_wdata[16i+15:16i]`. `sp_out` equals the start stack pointer plus 16. No `rf_we` bit is set before that cycle.
- R6: With `stack_wide` high, addresses and the new stack pointer use 32-bit arithmetic. With it low, address arithmetic wraps within 16 bits, `mem_addr[31:16]` is zero, and `sp_out[31:16]` equals `sp_in[31:16]`.
- R7: Once raised, `mem_req` holds with stable address, write flag and write data until `mem_ready` is sampled high. At most one transaction is outstanding.
- R8: When `fault` is sampled high while a transaction is being prepared or awaited, the block returns to idle. It pulses `abort` one cycle later and raises neither `done`, `sp_we` nor any `rf_we` bit for that sequence. A following start runs normally.
- R9: `start` is ignored while a sequence is in progress: no extra transaction and no second `done` follow.
- R10: `done` and `abort` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle launch pulse, sampled when idle |
| restore | input | 1 | Direction: 1 = restore from stack, 0 = save to stack |
| stack_wide | input | 1 | 1 = 32-bit stack address arithmetic, 0 = 16-bit wrap |
| sp_in | input | 32 | Current stack pointer, sampled with start |
| rf_rd_idx | output | 3 | Register index presented to the register-file read port |
| rf_rd_data | input | 16 | Register-file read data for `rf_rd_idx` |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in stack space |
| mem_wdata | output | 16 | Write data |
| mem_ready | input | 1 | Transaction accepted/completed in this cycle |
| mem_rdata | input | 16 | Read data, valid while `mem_ready` is high |
| fault | input | 1 | Cancels the sequence in flight |
| rf_we | output | 8 | Per-register write strobes for the commit |
| rf_wdata | output | 128 | Packed register values, register i at bits 16i+15:16i |
| sp_out | output | 32 | Updated stack pointer |
| sp_we | output | 1 | Stack pointer write strobe |
| done | output | 1 | Completion pulse |
| abort | output | 1 | Cancellation pulse |

## Verification
The handshake assertions take for granted that `mem_ready` is only raised while `mem_req` is high. They also assume that `fault` is the only way to withdraw a pending request. The bench's memory model answers only an active request, after a chosen latency, and drops `mem_ready` right after the accepting edge. The register-file read port is assumed to be asynchronous, so the bench drives `rf_rd_data` combinationally from `rf_rd_idx`. `start` and `fault` are driven as single-cycle pulses on the falling edge, so every sampled value is settled before the active edge.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PREP = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } rbs_state_e;

endpackage

// File: rtl/rbs_addr.sv
module rbs_addr #(
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int NREG     = 8,
  parameter int STRIDE   = 2,
  localparam int STEP_W  = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [STEP_W-1:0] step,
  input  logic              restore,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] sp_next
);

  localparam int FRAME = NREG * STRIDE;

  logic [ADDR_W-1:0] step_ext;
  logic [ADDR_W-1:0] full_addr;
  logic [ADDR_W-1:0] full_sp;

  always_comb begin
    step_ext = ADDR_W'(step);
    if (restore) begin
      full_addr = base + step_ext * ADDR_W'(STRIDE);
      full_sp   = base + ADDR_W'(FRAME);
    end else begin
      full_addr = base - (step_ext + 1'b1) * ADDR_W'(STRIDE);
      full_sp   = base - ADDR_W'(FRAME);
    end
  end

  generate
    if (ADDR_W > NARROW_W) begin : g_mixed
      always_comb begin
        if (wide) begin
          addr    = full_addr;
          sp_next = full_sp;
        end else begin
          addr    = {{(ADDR_W-NARROW_W){1'b0}}, full_addr[NARROW_W-1:0]};
          sp_next = {base[ADDR_W-1:NARROW_W], full_sp[NARROW_W-1:0]};
        end
      end
    end else begin : g_flat
      always_comb begin
        addr    = full_addr;
        sp_next = full_sp;
      end
    end
  endgenerate

endmodule

// File: rtl/rbs_shadow.sv
module rbs_shadow #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  output logic [NREG*DATA_W-1:0] bus
);

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_slot
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) begin
          q <= '0;
        end else if (wr_en && (wr_idx == IDX_W'(i))) begin
          q <= wr_data;
        end
      end
      assign bus[i*DATA_W +: DATA_W] = q;
    end
  endgenerate

endmodule

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int NREG    = 8,
  localparam int STEP_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              fault,
  input  logic              mem_ready,
  output rbs_state_e        state_q,
  output logic [STEP_W-1:0] step_q,
  output logic              launch,
  output logic              issue,
  output logic              beat_ok,
  output logic              cancel
);

  localparam logic [STEP_W-1:0] LAST = STEP_W'(NREG - 1);

  logic in_flight;

  always_comb begin
    in_flight = (state_q == ST_PREP) || (state_q == ST_XFER);
    launch    = (state_q == ST_IDLE) && start;
    cancel    = in_flight && fault;
    issue     = (state_q == ST_PREP) && !fault;
    beat_ok   = (state_q == ST_XFER) && !fault && mem_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_PREP;
            step_q  <= '0;
          end
        end
        ST_PREP: state_q <= fault ? ST_IDLE : ST_XFER;
        ST_XFER: begin
          if (fault) begin
            state_q <= ST_IDLE;
          end else if (mem_ready) begin
            if (step_q == LAST) begin
              state_q <= ST_DONE;
            end else begin
              step_q  <= step_q + 1'b1;
              state_q <= ST_PREP;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Guard: the step counter only advances through an accepted beat (R7).
  assert_step_moves_on_beat_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_XFER && !mem_ready) |=> (step_q == $past(step_q)));

  // Guard: a cancelled sequence is back in idle one cycle later (R8).
  assert_cancel_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
    cancel |=> (state_q == ST_IDLE));

endmodule

// File: rtl/regblk_stack_seq.sv
module regblk_stack_seq
  import rbs_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 32,
  parameter int NARROW_W = 16,
  parameter int NREG     = 8,
  parameter int SP_IDX   = 4,
  localparam int IDX_W   = $clog2(NREG),
  localparam int STRIDE  = DATA_W / 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   restore,
  input  logic                   stack_wide,
  input  logic [ADDR_W-1:0]      sp_in,
  output logic [IDX_W-1:0]       rf_rd_idx,
  input  logic [DATA_W-1:0]      rf_rd_data,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic                   mem_ready,
  input  logic [DATA_W-1:0]      mem_rdata,
  input  logic                   fault,
  output logic [NREG-1:0]        rf_we,
  output logic [NREG*DATA_W-1:0] rf_wdata,
  output logic [ADDR_W-1:0]      sp_out,
  output logic                   sp_we,
  output logic                   done,
  output logic                   abort
);

  localparam logic [NREG-1:0] COMMIT_MASK = ~(NREG'(1) << SP_IDX);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG - 1);

  rbs_state_e        state_q;
  logic [IDX_W-1:0]  step_q;
  logic              launch, issue, beat_ok, cancel;
  logic [ADDR_W-1:0] sp_base_q;
  logic              restore_q, wide_q;
  logic [ADDR_W-1:0] gen_addr, gen_sp;
  logic [IDX_W-1:0]  reg_idx;
  logic              shadow_wr;
  logic [NREG*DATA_W-1:0] shadow_bus;

  rbs_ctrl #(.NREG(NREG)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .fault     (fault),
    .mem_ready (mem_ready),
    .state_q   (state_q),
    .step_q    (step_q),
    .launch    (launch),
    .issue     (issue),
    .beat_ok   (beat_ok),
    .cancel    (cancel)
  );

  rbs_addr #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W),
    .NREG     (NREG),
    .STRIDE   (STRIDE)
  ) u_addr (
    .base    (sp_base_q),
    .step    (step_q),
    .restore (restore_q),
    .wide    (wide_q),
    .addr    (gen_addr),
    .sp_next (gen_sp)
  );

  // Save walks indices upward; restore walks them downward.
  assign reg_idx   = restore_q ? (TOP_IDX - step_q) : step_q;
  assign rf_rd_idx = reg_idx;
  assign shadow_wr = restore_q && beat_ok && (reg_idx != IDX_W'(SP_IDX));

  rbs_shadow #(.DATA_W(DATA_W), .NREG(NREG)) u_shadow (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (shadow_wr),
    .wr_idx  (reg_idx),
    .wr_data (mem_rdata),
    .bus     (shadow_bus)
  );

  // Sequence context captured at launch.
  always_ff @(posedge clk) begin
    if (rst) begin
      sp_base_q <= '0;
      restore_q <= 1'b0;
      wide_q    <= 1'b0;
    end else if (launch) begin
      sp_base_q <= sp_in;
      restore_q <= restore;
      wide_q    <= stack_wide;
    end
  end

  // Memory request channel.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else if (issue) begin
      mem_req   <= 1'b1;
      mem_we    <= !restore_q;
      mem_addr  <= gen_addr;
      mem_wdata <= (reg_idx == IDX_W'(SP_IDX)) ? sp_base_q[DATA_W-1:0] : rf_rd_data;
    end else if (beat_ok || cancel) begin
      mem_req <= 1'b0;
    end
  end

  // Completion outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      abort    <= 1'b0;
      sp_we    <= 1'b0;
      rf_we    <= '0;
      rf_wdata <= '0;
      sp_out   <= '0;
    end else begin
      done  <= (state_q == ST_DONE);
      abort <= cancel;
      sp_we <= (state_q == ST_DONE);
      rf_we <= ((state_q == ST_DONE) && restore_q) ? COMMIT_MASK : '0;
      if (state_q == ST_DONE) begin
        sp_out   <= gen_sp;
        rf_wdata <= shadow_bus;
      end
    end
  end

  // A pending request stays put until accepted or cancelled (R7).
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready && !fault) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // The discarded stack-pointer slot never reaches the register file (R4).
  assert_sp_slot_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    !rf_we[SP_IDX]);

  // Register strobes appear only with the completion pulse (R5).
  assert_commit_with_done_R5: assert property (@(posedge clk) disable iff (rst)
    (rf_we != '0) |-> (done && sp_we));

  // Narrow mode keeps the upper address bits clear (R6).
  assert_narrow_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !wide_q) |-> (mem_addr[ADDR_W-1:NARROW_W] == '0));

  // An aborted sequence commits nothing (R8).
  assert_abort_no_commit_R8: assert property (@(posedge clk) disable iff (rst)
    abort |-> (!sp_we && (rf_we == '0)));

  // Completion and abort are exclusive single-cycle pulses (R10).
  assert_done_abort_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(done && abort));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: tb/regblk_stack_seq_bench.sv
module regblk_stack_seq_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         restore = 1'b0;
  logic         stack_wide = 1'b0;
  logic [31:0]  sp_in = '0;
  logic [2:0]   rf_rd_idx;
  logic [15:0]  rf_rd_data;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [15:0]  mem_wdata;
  logic         mem_ready = 1'b0;
  logic [15:0]  mem_rdata = '0;
  logic         fault = 1'b0;
  logic [7:0]   rf_we;
  logic [127:0] rf_wdata;
  logic [31:0]  sp_out;
  logic         sp_we, done, abort;

  always #10 clk = ~clk;

  regblk_stack_seq u_regblk_stack_seq (
    .clk(clk), .rst(rst), .start(start), .restore(restore),
    .stack_wide(stack_wide), .sp_in(sp_in), .rf_rd_idx(rf_rd_idx),
    .rf_rd_data(rf_rd_data), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .fault(fault), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .sp_out(sp_out), .sp_we(sp_we),
    .done(done), .abort(abort)
  );

  logic [15:0] rf [8];
  assign rf_rd_data = rf[rf_rd_idx];

  logic [15:0] mem [int unsigned];
  int          lat = 0;
  int          wait_cnt = 0;
  int          n_txn = 0;
  logic [31:0] t_addr [16];
  logic        t_we   [16];
  logic [15:0] t_data [16];
  int          done_cnt = 0;
  int          abort_cnt = 0;
  int          errors = 0;
  int          checks = 0;

  // Snapshot of the completion cycle.
  logic         s_done, s_abort, s_sp_we;
  logic [7:0]   s_rf_we;
  logic [127:0] s_rf_wdata;
  logic [31:0]  s_sp_out;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: answers an active request after lat cycles.
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
    end else if (mem_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt  = 0;
        mem_ready = 1'b1;
        if (n_txn < 16) begin
          t_addr[n_txn] = mem_addr;
          t_we[n_txn]   = mem_we;
          t_data[n_txn] = mem_wdata;
        end
        n_txn++;
        if (mem_we) mem[mem_addr] = mem_wdata;
        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 16'h0000;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (done) done_cnt++;
      if (abort) abort_cnt++;
    end
  end

  // Runs one sequence; fault_cyc/extra_start < 0 disables the injection.
  task automatic run_op(input bit dir, input bit wide, input logic [31:0] sp,
                        input int latency, input int fault_cyc, input int extra_start);
    lat = latency;
    n_txn = 0;
    @(negedge clk);
    restore = dir; stack_wide = wide; sp_in = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    restore = ~dir; sp_in = ~sp;
    s_done = 0; s_abort = 0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (done || abort) begin
        s_done = done; s_abort = abort; s_sp_we = sp_we;
        s_rf_we = rf_we; s_rf_wdata = rf_wdata; s_sp_out = sp_out;
        break;
      end
      fault = (c == fault_cyc);
      start = (c == extra_start);
    end
    fault = 1'b0;
    start = 1'b0;
  endtask

  function automatic logic [31:0] stk(input bit wide, input logic [31:0] sp, input int off);
    logic [31:0] f = sp + 32'(off);
    return wide ? f : {16'h0000, f[15:0]};
  endfunction

  task automatic test_save(input bit wide, input logic [31:0] sp, input int latency, input string name);
    int d0 = done_cnt;
    for (int i = 0; i < 8; i++) rf[i] = 16'h1000 * 16'(i + 1) + 16'(sp[7:0]);
    run_op(1'b0, wide, sp, latency, -1, -1);
    check(s_done == 1'b1, {name, " R3 done"}, 32'(s_done), 1);
    check(n_txn == 8, {name, " R1 txn count"}, n_txn, 8);
    for (int k = 0; k < 8; k++) begin
      logic [15:0] ed = (k == 4) ? sp[15:0] : rf[k];
      check(t_we[k] == 1'b1, {name, " R1 write flag"}, 32'(t_we[k]), 1);
      check(t_addr[k] == stk(wide, sp, -2 * (k + 1)), {name, " R1 R6 address"}, t_addr[k], stk(wide, sp, -2 * (k + 1)));
      check(t_data[k] == ed, {name, (k == 4) ? " R2 sp slot" : " R1 data"}, 32'(t_data[k]), 32'(ed));
    end
    check(s_sp_we == 1'b1, {name, " R3 sp_we"}, 32'(s_sp_we), 1);
    check(s_rf_we == 8'h00, {name, " R3 rf_we"}, 32'(s_rf_we), 0);
    begin
      logic [31:0] e = wide ? sp - 32'd16 : {sp[31:16], sp[15:0] - 16'd16};
      check(s_sp_out == e, {name, " R3 R6 sp_out"}, s_sp_out, e);
    end
    @(negedge clk);
    check(done == 1'b0, {name, " R10 done pulse"}, 32'(done), 0);
    check(done_cnt == d0 + 1, {name, " R10 done count"}, done_cnt, d0 + 1);
  endtask

  task automatic test_restore(input bit wide, input logic [31:0] sp, input int latency, input string name);
    int d0 = done_cnt;
    for (int k = 0; k < 8; k++) mem[stk(wide, sp, 2 * k)] = 16'hA000 + 16'(k * 16'h0111) + 16'(sp[3:0]);
    run_op(1'b1, wide, sp, latency, -1, -1);
    check(s_done == 1'b1, {name, " R5 done"}, 32'(s_done), 1);
    check(n_txn == 8, {name, " R4 txn count"}, n_txn, 8);
    for (int k = 0; k < 8; k++) begin
      check(t_we[k] == 1'b0, {name, " R4 read flag"}, 32'(t_we[k]), 0);
      check(t_addr[k] == stk(wide, sp, 2 * k), {name, " R4 R6 address"}, t_addr[k], stk(wide, sp, 2 * k));
      if (k != 3) begin
        logic [15:0] got = s_rf_wdata[(7 - k) * 16 +: 16];
        logic [15:0] e = mem[stk(wide, sp, 2 * k)];
        check(got == e, {name, " R4 R5 register value"}, 32'(got), 32'(e));
      end
    end
    check(s_rf_we == 8'b1110_1111, {name, " R5 R4 rf_we mask"}, 32'(s_rf_we), 32'hEF);
    check(s_sp_we == 1'b1, {name, " R5 sp_we"}, 32'(s_sp_we), 1);
    begin
      logic [31:0] e = wide ? sp + 32'd16 : {sp[31:16], sp[15:0] + 16'd16};
      check(s_sp_out == e, {name, " R5 R6 sp_out"}, s_sp_out, e);
    end
    @(negedge clk);
    check(rf_we == 8'h00, {name, " R5 single commit"}, 32'(rf_we), 0);
    check(done_cnt == d0 + 1, {name, " R10 done count"}, done_cnt, d0 + 1);
  endtask

  task automatic test_fault(input bit dir, input int fcyc, input string name);
    int d0 = done_cnt;
    int a0 = abort_cnt;
    run_op(dir, 1'b0, 32'h0000_0200, 0, fcyc, -1);
    check(s_abort == 1'b1, {name, " R8 abort"}, 32'(s_abort), 1);
    check(s_done == 1'b0, {name, " R8 R10 no done"}, 32'(s_done), 0);
    check(s_sp_we == 1'b0, {name, " R8 no sp_we"}, 32'(s_sp_we), 0);
    check(s_rf_we == 8'h00, {name, " R8 no rf_we"}, 32'(s_rf_we), 0);
    repeat (4) @(negedge clk);
    check(mem_req == 1'b0, {name, " R8 idle"}, 32'(mem_req), 0);
    check(n_txn < 8, {name, " R8 cut short"}, n_txn, 7);
    check(done_cnt == d0, {name, " R8 no later done"}, done_cnt, d0);
    check(abort_cnt == a0 + 1, {name, " R10 abort pulse"}, abort_cnt, a0 + 1);
  endtask

  task automatic test_busy_start;
    int d0 = done_cnt;
    for (int i = 0; i < 8; i++) rf[i] = 16'h0F00 + 16'(i);
    run_op(1'b0, 1'b0, 32'h0000_0400, 1, -1, 3);
    check(s_done == 1'b1, "busy R9 done", 32'(s_done), 1);
    for (int k = 0; k < 8; k++)
      check(t_we[k] == 1'b1, "busy R9 direction kept", 32'(t_we[k]), 1);
    repeat (6) @(negedge clk);
    check(n_txn == 8, "busy R9 txn count", n_txn, 8);
    check(mem_req == 1'b0, "busy R9 no extra request", 32'(mem_req), 0);
    check(done_cnt == d0 + 1, "busy R9 single done", done_cnt, d0 + 1);
  endtask

  task automatic test_reset;
    check(mem_req == 1'b0, "reset mem_req", 32'(mem_req), 0);
    check(done == 1'b0 && abort == 1'b0, "reset R10 pulses", 32'({done, abort}), 0);
    check(rf_we == 8'h00 && sp_we == 1'b0, "reset strobes", 32'({rf_we, sp_we}), 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_save(1'b0, 32'h1234_0004, 0, "save16 wrap");
    test_save(1'b1, 32'h0010_0004, 2, "save32 carry");
    test_restore(1'b0, 32'hABCD_FFF8, 0, "restore16 wrap");
    test_restore(1'b1, 32'h0001_FFF8, 3, "restore32 carry");
    test_fault(1'b0, 5, "fault save");
    test_fault(1'b1, 8, "fault restore");
    test_save(1'b0, 32'h0000_3000, 1, "save after fault");
    test_busy_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule